// File: doc/BRIEF.md
# Gated Asynchronous Serial Byte Receiver

This block receives asynchronous serial frames of one start bit, eight data bits and one stop bit. It runs from the master clock with no second oscillator. A falling level on the idle line starts a frame and loads a bit-period counter. The counter then produces one sampling strobe near the middle of each bit period. The first strobe checks the start bit again, so a short glitch is rejected. The next eight strobes shift the data in least significant bit first. The tenth strobe checks the stop bit.

A flow-control input gates the whole receiver. While it is low, the bit-period counter, the bit index and the state machine all hold their values. A frame that is paused this way continues where it stopped when the input goes high again. A good frame gives the byte with a one-cycle valid pulse. A bad start bit or a bad stop bit sets a sticky framing-error flag. The flag stays set until reset or until the clear input is pulsed. The bit period and the sample point are parameters, so a different master clock only changes these two values.

Top module: `uart_rx_gated`

## Requirements
- R1: After a synchronous reset, `rx_valid` and `frame_err` are 0 and `rx_data` is 0x00.
- R2: While idle and `cts` is high, a low level on the synchronized line starts a frame. The line is sampled once per `BIT_CLKS` cycles, at count `SAMPLE_AT` of each period. The eight data samples form `rx_data` least significant bit first: the first data bit lands in bit 0.
- R3: When a high stop bit is sampled, `rx_valid` is high for exactly one cycle and `rx_data` holds the new byte. `rx_data` changes only in a cycle where `rx_valid` is high.
- R4: If the start bit samples high at its mid-point, `frame_err` is set, no byte is delivered, and the receiver returns to idle.
- R5: If the stop bit samples low, `frame_err` is set, `rx_valid` stays low, and `rx_data` keeps the last good byte.
- R6: While `cts` is low, nothing in a frame advances and `rx_valid` stays low. A frame paused in the middle finishes correctly once `cts` is high again.
- R7: While `cts` is low and the receiver is idle, a falling edge on the line does not start a frame. After `cts` rises on a high line, no byte and no error appear.
- R8: `frame_err` stays set until `err_clr` is pulsed. A one-cycle pulse on `err_clr` clears it.
- R9: Frames sent back to back, each start bit following the previous stop bit at once, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial data line, idle high |
| cts | input | 1 | Receive enable; when low, all receiver state holds its value |
| err_clr | input | 1 | Pulse to clear the framing-error flag |
| rx_data | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle pulse when a new byte is in `rx_data` |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The hardest case is a pause in the middle of a frame. `cts` must go low while a bit is on the line, and the serial driver must then hold that bit for the whole pause, so that the frozen counter still lines up with the bits on resume. The bench makes this happen in its frame task: it drops `cts` a quarter of the way into a chosen data bit and stretches that bit by the pause length. A glitch that looks like a start bit is made with a low pulse shorter than the sample point. The falling edge then starts the counter, but the mid-point re-check reads high.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RECV = 1'b1
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int BIT_CLKS  = 434,
  parameter int SAMPLE_AT = 217
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic advance,
  output logic strobe
);
  localparam int CW = $clog2(BIT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS);
  localparam logic [CW-1:0] MID  = CW'(SAMPLE_AT);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ONE;
    end else if (restart) begin
      cnt <= ONE;
    end else if (run && advance) begin
      if (cnt == LAST) cnt <= ONE;
      else             cnt <= cnt + ONE;
    end
  end

  assign strobe = run && advance && (cnt == MID);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cts,
  input  logic                 line,
  input  logic                 strobe,
  input  logic                 err_clr,
  output logic                 busy,
  output logic                 restart,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 valid_q,
  output logic                 err_q
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int IW = $clog2(FRAME_BITS + 1);
  localparam logic [IW-1:0] STOP_IDX = IW'(FRAME_BITS - 1);

  rx_state_t            state;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 bad_start, bad_stop, good_stop;

  assign busy      = (state == RX_RECV);
  assign restart   = (state == RX_IDLE) && cts && !line;
  assign bad_start = strobe && (idx == '0) && line;
  assign bad_stop  = strobe && (idx == STOP_IDX) && !line;
  assign good_stop = strobe && (idx == STOP_IDX) && line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      idx   <= '0;
      shreg <= '0;
    end else if (restart) begin
      state <= RX_RECV;
      idx   <= '0;
    end else if (strobe) begin
      if (bad_start || idx == STOP_IDX) begin
        state <= RX_IDLE;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
        if (idx != '0) shreg <= {line, shreg[DATA_BITS-1:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= good_stop;
      if (good_stop) data_q <= shreg;
      if (bad_start || bad_stop) err_q <= 1'b1;
      else if (err_clr)          err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_gated.sv
module uart_rx_gated #(
  parameter int BIT_CLKS  = 434,
  parameter int SAMPLE_AT = 217,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd,
  input  logic                 cts,
  input  logic                 err_clr,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err
);
  logic line_s, busy, restart, strobe;

  rx_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  rx_bit_timer #(.BIT_CLKS(BIT_CLKS), .SAMPLE_AT(SAMPLE_AT)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .run(busy),
    .advance(cts), .strobe(strobe)
  );

  rx_frame_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
    .clk(clk), .rst(rst), .cts(cts), .line(line_s), .strobe(strobe),
    .err_clr(err_clr), .busy(busy), .restart(restart),
    .data_q(rx_data), .valid_q(rx_valid), .err_q(frame_err)
  );
endmodule

// File: rtl/uart_rx_gated_checker.sv
module uart_rx_gated_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cts,
  input logic                 err_clr,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 frame_err
);
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_data_only_on_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> rx_valid);

  assert_freeze_no_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !cts |=> !rx_valid);

  assert_freeze_err_R6: assert property (@(posedge clk) disable iff (rst)
    (!cts && !err_clr) |=> $stable(frame_err));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_err && !err_clr) |=> frame_err);

  assert_no_valid_with_new_err_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> !rx_valid);
endmodule

bind uart_rx_gated uart_rx_gated_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .cts(cts), .err_clr(err_clr),
  .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
);

// File: tb/uart_rx_gated_test.sv
module uart_rx_gated_test;
  localparam int BITC = 16;
  localparam int SAMP = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       cts = 1'b1;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       frame_err;

  int checks = 0;
  int fails = 0;
  int valid_cnt = 0;
  logic [7:0] last_good = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_gated #(.BIT_CLKS(BITC), .SAMPLE_AT(SAMP)) uut (
    .clk(clk), .rst(rst), .rxd(rxd), .cts(cts), .err_clr(err_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
  );

  always @(negedge clk) if (!rst && rx_valid) valid_cnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one serial bit, optionally pausing cts for stall cycles inside it
  task automatic drive_bit(input logic v, input int stall);
    rxd = v;
    if (stall > 0) begin
      cyc(BITC / 4);
      cts = 1'b0;
      cyc(stall);
      cts = 1'b1;
      cyc(BITC - BITC / 4);
    end else begin
      cyc(BITC);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop,
                            input int stall_bit, input int stall, input int gap);
    drive_bit(1'b0, 0);
    for (int i = 0; i < 8; i++) drive_bit(b[i], (i == stall_bit) ? stall : 0);
    if (stop) drive_bit(1'b1, 0);
    else begin
      rxd = 1'b0;
      cyc(SAMP + 6);
      rxd = 1'b1;
      cyc(BITC - SAMP - 6);
    end
    rxd = 1'b1;
    cyc(gap);
  endtask

  task automatic test_reset;
    chk("R1 valid", rx_valid, 0);
    chk("R1 err", frame_err, 0);
    chk("R1 data", rx_data, 8'h00);
  endtask

  task automatic test_byte(input logic [7:0] b);
    int v0 = valid_cnt;
    send_frame(b, 1'b1, -1, 0, 2 * BITC);
    chk("R2 data LSB first", rx_data, b);
    chk("R3 one valid pulse", valid_cnt - v0, 1);
    chk("R2 no error", frame_err, 0);
    last_good = b;
  endtask

  task automatic test_back_to_back;
    int v0 = valid_cnt;
    send_frame(8'h3C, 1'b1, -1, 0, 0);
    send_frame(8'hC3, 1'b1, -1, 0, 2 * BITC);
    chk("R9 two bytes", valid_cnt - v0, 2);
    chk("R9 last byte", rx_data, 8'hC3);
    chk("R9 no error", frame_err, 0);
    last_good = 8'hC3;
  endtask

  task automatic test_stall;
    int v0 = valid_cnt;
    send_frame(8'h5A, 1'b1, 3, 40, 2 * BITC);
    chk("R6 byte after pause", rx_data, 8'h5A);
    chk("R6 one valid", valid_cnt - v0, 1);
    chk("R6 no error", frame_err, 0);
    last_good = 8'h5A;
  endtask

  task automatic test_cts_idle;
    int v0 = valid_cnt;
    cts = 1'b0;
    send_frame(8'h00, 1'b1, -1, 0, BITC);
    cts = 1'b1;
    cyc(3 * BITC);
    chk("R7 no valid", valid_cnt - v0, 0);
    chk("R7 no error", frame_err, 0);
    chk("R7 data kept", rx_data, last_good);
  endtask

  task automatic clear_err;
    err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;
    cyc(1);
  endtask

  task automatic test_bad_start;
    int v0 = valid_cnt;
    rxd = 1'b0;
    cyc(3);
    rxd = 1'b1;
    cyc(2 * BITC);
    chk("R4 err set", frame_err, 1);
    chk("R4 no valid", valid_cnt - v0, 0);
    cyc(5 * BITC);
    chk("R8 err still set", frame_err, 1);
    clear_err();
    chk("R8 err cleared", frame_err, 0);
  endtask

  task automatic test_bad_stop;
    int v0 = valid_cnt;
    send_frame(8'h77, 1'b0, -1, 0, 3 * BITC);
    chk("R5 err set", frame_err, 1);
    chk("R5 no valid", valid_cnt - v0, 0);
    chk("R5 data kept", rx_data, last_good);
    clear_err();
    chk("R8 cleared", frame_err, 0);
    test_byte(8'h96);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(2);
    test_reset();
    test_byte(8'hA5);
    test_byte(8'h01);
    test_byte(8'h80);
    test_back_to_back();
    test_stall();
    test_cts_idle();
    test_bad_start();
    test_bad_stop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule